// File: doc/BRIEF.md
# Nibble-Folded NVRAM Checksum Engine

This block walks a region of a byte-addressed non-volatile memory and reduces it to a 16-bit checksum. A start pulse captures a base address and a byte count. The engine then issues one byte read per clock on a synchronous read port with one cycle of latency. Each byte it gets back is folded into a running 16-bit accumulator. When the walk ends, the engine raises a one-cycle done pulse, and the checksum stays on its output until the next run completes.

The update step does not use a shifted polynomial register. It is a closed-form fold that works on the low two nibbles of the XOR between the accumulator and a 16-bit step value. Each step value is a big-endian pair of neighbouring bytes, and each new pair starts one byte after the previous pair. Every fetched byte therefore serves as the low byte of one step and then as the high byte of the next step. A region with an odd length ends with one extra step whose low byte is zero. Firmware checksums its configuration block this way over bytes 0x00 to 0xF7. A separate writer stores the result, and that writer is not part of this block.

Top module: `nvcsum_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy_o`, `done_o` and `mem_rd_en_o` are 0 and `csum_o` is 0x0000.
- R2: The accumulator is loaded with 0xFFFF when a run is accepted. A run with count 0 issues no reads and ends with `csum_o` = 0xFFFF.
- R3: One step with accumulator A and value V is computed as follows. Let d = (A ^ V)[7:0], a = d[3:0] and b = d[7:4] ^ a. The new accumulator is (A >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12), truncated to 16 bits. A one-byte run over a zero byte therefore gives 0x0F87.
- R4: Let E be the count with bit 0 cleared. For i = 0 to E-1, step i uses the value {mem[S+i], mem[S+i+1]}, where S is the start address and the first byte is the high byte.
- R5: When bit 0 of the count is 1, one final step uses {mem[S+E], 8'h00}. This byte comes from a read that was already made, or from a single read when E = 0.
- R6: The engine reads each address once, in ascending order. The addresses run from S to S+E when E > 0, or are just S when the count is 1. Addresses wrap modulo 2^13.
- R7: `done_o` is high for exactly one cycle. `csum_o` changes only in the cycle in which `done_o` is high. `busy_o` is high from the cycle after an accepted start until the done cycle.
- R8: A start pulse while `busy_o` is high has no effect on the run in progress, on its reads or on its result, and it does not start a further run.
- R9: A run over offset 0x000 with count 0xF8 gives the checksum of R2 to R5 for the configuration block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| start_addr_i | input | 13 | First byte address of the region |
| count_i | input | 14 | Number of bytes in the region |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| csum_o | output | 16 | Checksum of the last finished run |
| mem_rd_en_o | output | 1 | Memory read strobe |
| mem_rd_addr_o | output | 13 | Memory read address |
| mem_rd_data_i | input | 8 | Read data, valid one cycle after the strobe |

## Verification
Two situations are hard to reach from the ports. The first is a start pulse that arrives in the middle of a run. The bench drives a second start with a different address and count two cycles after the first start has been accepted. It then checks that the reads and the result belong only to the first run, and that no second run follows. The second is address wrap at the top of memory. The bench starts a region a few bytes below 0x1FFF and watches the read addresses roll over to 0x0000.

// File: rtl/nvcsum_pkg.sv
package nvcsum_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_WAIT = 3'd2,
    ST_TAIL = 3'd3,
    ST_FIN  = 3'd4
  } nvcsum_state_e;

  localparam logic [15:0] CSUM_SEED = 16'hFFFF;

  function automatic logic [15:0] nib_fold(input logic [15:0] acc, input logic [15:0] val);
    logic [7:0]  mix;
    logic [15:0] lo;
    logic [15:0] hi;
    mix = acc[7:0] ^ val[7:0];
    lo  = {12'h000, mix[3:0]};
    hi  = {12'h000, mix[7:4] ^ mix[3:0]};
    return {8'h00, acc[15:8]} ^ (lo << 3) ^ (lo << 8) ^ hi ^ (hi << 7) ^ (hi << 12);
  endfunction

endpackage

// File: rtl/nvcsum_fold.sv
module nvcsum_fold (
  input  logic [15:0] acc_i,
  input  logic [15:0] val_i,
  output logic [15:0] next_o
);
  import nvcsum_pkg::*;

  always_comb next_o = nib_fold(acc_i, val_i);
endmodule

// File: rtl/nvcsum_addr_gen.sv
module nvcsum_addr_gen #(
  parameter int ADDR_W = 13,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  nreads_i,
  input  logic              issue_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              vld_o,
  output logic              first_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  nreads_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      idx_q    <= '0;
      nreads_q <= '0;
      vld_o    <= 1'b0;
      first_o  <= 1'b0;
    end else begin
      vld_o   <= issue_i;
      first_o <= issue_i && (idx_q == '0);
      if (load_i) begin
        base_q   <= base_i;
        nreads_q <= nreads_i;
        idx_q    <= '0;
      end else if (issue_i) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    addr_o = base_q + idx_q[ADDR_W-1:0];
    last_o = (idx_q + 1'b1) == nreads_q;
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (issue_i && $past(issue_i)) |-> (addr_o == $past(addr_o) + 1'b1)) else $error("addr step"); // R6
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    issue_i |-> (idx_q < nreads_q)) else $error("idx bound"); // R6
endmodule

// File: rtl/nvcsum_accum.sv
module nvcsum_accum (
  input  logic       clk,
  input  logic       rst,
  input  logic       init_i,
  input  logic       vld_i,
  input  logic       first_i,
  input  logic       tail_i,
  input  logic [7:0] data_i,
  output logic [15:0] acc_o
);
  import nvcsum_pkg::*;

  logic [7:0]  hold_q;
  logic [15:0] step_val;
  logic [15:0] folded;
  logic        do_step;

  always_comb begin
    step_val = tail_i ? {hold_q, 8'h00} : {hold_q, data_i};
    do_step  = tail_i || (vld_i && !first_i);
  end

  nvcsum_fold fold_i (
    .acc_i (acc_o),
    .val_i (step_val),
    .next_o(folded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o  <= CSUM_SEED;
      hold_q <= 8'h00;
    end else begin
      if (init_i) acc_o <= CSUM_SEED;
      else if (do_step) acc_o <= folded;
      if (vld_i) hold_q <= data_i;
    end
  end

  AST_INIT_VALUE: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (acc_o == CSUM_SEED)) else $error("seed"); // R2
endmodule

// File: rtl/nvcsum_top.sv
module nvcsum_top #(
  parameter int ADDR_W = 13,
  parameter int CNT_W  = ADDR_W + 1,
  parameter int SUM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SUM_W-1:0]  csum_o,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [7:0]        mem_rd_data_i
);
  import nvcsum_pkg::*;

  nvcsum_state_e state_q;
  logic              odd_q;
  logic              accept;
  logic [CNT_W-1:0]  even_cnt;
  logic [CNT_W-1:0]  nreads;
  logic              last;
  logic              vld;
  logic              first;
  logic [15:0]       acc;

  always_comb begin
    accept   = start_i && (state_q == ST_IDLE);
    even_cnt = {count_i[CNT_W-1:1], 1'b0};
    nreads   = (even_cnt == '0) ? {{(CNT_W-1){1'b0}}, count_i[0]} : even_cnt + 1'b1;
    busy_o      = (state_q != ST_IDLE);
    mem_rd_en_o = (state_q == ST_READ);
  end

  nvcsum_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) agen_i (
    .clk     (clk),
    .rst     (rst),
    .load_i  (accept),
    .base_i  (start_addr_i),
    .nreads_i(nreads),
    .issue_i (mem_rd_en_o),
    .addr_o  (mem_rd_addr_o),
    .last_o  (last),
    .vld_o   (vld),
    .first_o (first)
  );

  nvcsum_accum accum_i (
    .clk    (clk),
    .rst    (rst),
    .init_i (accept),
    .vld_i  (vld),
    .first_i(first),
    .tail_i (state_q == ST_TAIL),
    .data_i (mem_rd_data_i),
    .acc_o  (acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      odd_q   <= 1'b0;
      done_o  <= 1'b0;
      csum_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          odd_q   <= count_i[0];
          state_q <= (nreads == '0) ? ST_FIN : ST_READ;
        end
        ST_READ: if (last) state_q <= ST_WAIT;
        ST_WAIT: state_q <= odd_q ? ST_TAIL : ST_FIN;
        ST_TAIL: state_q <= ST_FIN;
        ST_FIN: begin
          csum_o  <= SUM_W'(acc);
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o) else $error("done pulse"); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(csum_o) |-> done_o) else $error("result held"); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o) else $error("done idle"); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o)) else $error("busy start"); // R8
endmodule

// File: tb/nvcsum_top_tb.sv
module nvcsum_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int CW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [CW-1:0] count_i = '0;
  logic          busy_o, done_o, mem_rd_en_o;
  logic [15:0]   csum_o;
  logic [AW-1:0] mem_rd_addr_o;
  logic [7:0]    mem_rd_data_i = 8'h00;

  int n_checks = 0;
  int n_fail = 0;
  int mon_reads = 0;
  int mon_bad = 0;
  logic [AW-1:0] mon_next = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvcsum_top dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .count_i(count_i), .busy_o(busy_o), .done_o(done_o), .csum_o(csum_o),
    .mem_rd_en_o(mem_rd_en_o), .mem_rd_addr_o(mem_rd_addr_o),
    .mem_rd_data_i(mem_rd_data_i)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    int v;
    if (a >= 13'h1000 && a <= 13'h1007) return 8'h00;
    v = int'(a) * 29 + (int'(a) >> 5) * 7 + 3;
    return v[7:0];
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en_o) begin
      mem_rd_data_i <= pat(mem_rd_addr_o);
      if (mem_rd_addr_o != mon_next) mon_bad++;
      mon_next = mon_next + 1'b1;
      mon_reads++;
    end
  end

  function automatic logic [15:0] ref_step(input logic [15:0] a, input logic [15:0] v);
    int d, x, y, r;
    d = int'(a ^ v) & 255;
    x = d & 15;
    y = ((d >> 4) & 15) ^ x;
    r = (int'(a) >> 8) ^ (x * 8) ^ (x * 256) ^ y ^ (y * 128) ^ (y * 4096);
    return r[15:0];
  endfunction

  function automatic logic [15:0] ref_csum(input logic [AW-1:0] s, input int cnt);
    logic [15:0] c;
    int ev;
    c = 16'hFFFF;
    ev = cnt & ~1;
    for (int i = 0; i < ev; i++)
      c = ref_step(c, {pat(s + AW'(i)), pat(s + AW'(i + 1))});
    if (cnt % 2 == 1) c = ref_step(c, {pat(s + AW'(ev)), 8'h00});
    return c;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic run(input logic [AW-1:0] s, input int cnt, output logic [15:0] res);
    int t;
    @(negedge clk);
    mon_next = s; mon_reads = 0; mon_bad = 0;
    start_addr_i = s; count_i = CW'(cnt); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t = 0;
    while (!done_o && t < 20000) begin @(negedge clk); t++; end
    res = csum_o;
  endtask

  task automatic do_region(input string req, input logic [AW-1:0] s, input int cnt);
    logic [15:0] r;
    int ev, exp_reads;
    ev = cnt & ~1;
    exp_reads = (ev > 0) ? ev + 1 : (cnt % 2);
    run(s, cnt, r);
    check(req, int'(r), int'(ref_csum(s, cnt)));
    check({req, " R6 reads"}, mon_reads, exp_reads);
    check({req, " R6 order"}, mon_bad, 0);
  endtask

  task automatic t_reset;
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 rd_en", int'(mem_rd_en_o), 0);
    check("R1 csum", int'(csum_o), 0);
  endtask

  task automatic t_zero;
    logic [15:0] r;
    run(13'h0123, 0, r);
    check("R2 zero count", int'(r), 16'hFFFF);
    check("R2 no reads", mon_reads, 0);
  endtask

  task automatic t_known;
    logic [15:0] r;
    run(13'h1000, 1, r);
    check("R3 R5 one zero byte", int'(r), 16'h0F87);
  endtask

  task automatic t_pulse;
    logic [15:0] r;
    run(13'h0040, 5, r);
    check("R7 done high", int'(done_o), 1);
    @(negedge clk);
    check("R7 done drop", int'(done_o), 0);
    check("R7 busy low", int'(busy_o), 0);
    repeat (3) @(negedge clk);
    check("R7 held", int'(csum_o), int'(r));
  endtask

  task automatic t_busy_start;
    logic [15:0] r;
    int t;
    @(negedge clk);
    mon_next = 13'h0200; mon_reads = 0; mon_bad = 0;
    start_addr_i = 13'h0200; count_i = 14'd40; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R7 busy after start", int'(busy_o), 1);
    @(negedge clk);
    start_addr_i = 13'h0777; count_i = 14'd9; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t = 0;
    while (!done_o && t < 20000) begin @(negedge clk); t++; end
    r = csum_o;
    check("R8 result of first run", int'(r), int'(ref_csum(13'h0200, 40)));
    check("R8 reads of first run", mon_reads, 41);
    check("R8 order", mon_bad, 0);
    repeat (6) @(negedge clk);
    check("R8 no second run", int'(busy_o), 0);
    check("R8 no extra reads", mon_reads, 41);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero();
    t_known();
    do_region("R4 two bytes", 13'h0010, 2);
    do_region("R4 R5 odd seven", 13'h0333, 7);
    do_region("R5 single byte", 13'h0404, 1);
    do_region("R6 wrap", 13'h1FFC, 6);
    do_region("R6 wrap odd", 13'h1FFD, 5);
    do_region("R9 config block", 13'h0000, 248);
    t_pulse();
    t_busy_start();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule